// File: doc/BRIEF.md
# BCD Clock-Calendar Register Bank

This block places a clock-calendar in the eight highest byte addresses of a small byte-wide memory. All lower addresses reach a plain synchronous RAM. The bus is a chip-enable, write-enable and output-enable port, sampled on the clock edge. The time counters advance once for each cycle in which the one-per-second `tick` input is high. Each field is kept as packed BCD. Seconds carry into minutes, minutes into hours, and hours into both the day-of-week and the date. The date carries into the month according to month length, and the month carries into the year.

Software sets the time by raising a freeze bit in the control byte. While that bit is high, field writes go to a staging copy. Clearing it loads the staging copy into the live counters. A second control bit takes a snapshot, so that a multi-byte read cannot tear while the counters keep running. A stop bit in the seconds byte blocks the tick. A power-fail input cuts off every access and pulls the reset output low. Bits that no time function claims behave as ordinary storage.

Top module: `rtc_regbank`

## Requirements
- R1: The eight highest addresses are the register bank. Offset 7 is year (BCD, 8 bits), 6 is month (bits 4:0), 5 is date (bits 5:0), 4 is day-of-week (bits 2:0), 3 is hour (bits 5:0), 2 is minutes (bits 6:0), 1 is seconds (bits 6:0) and 0 is control.
- R2: A write takes place when `ce_n`=0 and `we_n`=0 at a clock edge. A read takes place when `ce_n`=0 and `we_n`=1, and its data appears on `rdata` after that edge. `rdata` is 0 whenever `oe_n`=1. Addresses below the bank reach a RAM of `RAM_DEPTH` bytes, indexed by the low address bits.
- R3: Every bit outside a time field stores the last value written to it and returns that value on a read. This includes control bits 7 (freeze) and 6 (snapshot), seconds bit 7 (stop) and day bit 6 (frequency test).
- R4: While freeze is 1, field writes go to a staging copy, reads of time fields return that copy, and the live counters keep counting. Setting freeze copies the live time into the staging copy. Clearing freeze loads the staging copy into the live counters. While freeze is 0, writes to time fields are ignored.
- R5: Setting the snapshot bit captures the live time. While the bit is 1 (and freeze is 0), time-field reads return that capture, and the counters keep running.
- R6: While seconds bit 7 is 1, the tick has no effect on the time.
- R7: A tick increments seconds in BCD. Each field wraps to its lower limit and carries into the next: seconds 59, minutes 59, hour 23, day-of-week 7→1, date at month end, month 12→01, year 99→00. February ends on 29 when the year is a multiple of 4, and on 28 otherwise.
- R8: While `pwr_fail` is 1, `rst_out_n` is 0, no write changes any storage, and no read changes `rdata`.
- R9: After reset the time is 00:00:00, day 01, date 01, month 01, year 00. All stored bits are 0 and `rdata` is 0.
- R10: When the load that comes from clearing freeze falls in the same cycle as a tick, the load wins and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| pwr_fail | input | 1 | Power-fail indication, active high |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when `oe_n` is high |
| rst_out_n | output | 1 | Reset output, low during power fail |

## Verification
Two events can land on the same edge: the load of the counters that comes from clearing the freeze bit, and a second tick. The bench drives the control write that clears freeze with `tick` high in that same cycle. It then reads the seconds byte. The result must equal the staged value exactly, not that value plus one. A further tick must then advance it by one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG = 8;
  localparam logic [2:0] IX_CTRL = 3'd0;
  localparam logic [2:0] IX_SEC  = 3'd1;
  localparam logic [2:0] IX_MIN  = 3'd2;
  localparam logic [2:0] IX_HR   = 3'd3;
  localparam logic [2:0] IX_DOW  = 3'd4;
  localparam logic [2:0] IX_DATE = 3'd5;
  localparam logic [2:0] IX_MON  = 3'd6;
  localparam logic [2:0] IX_YR   = 3'd7;

  typedef struct packed {
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{yr: 8'h00, mon: 5'h01, date: 6'h01,
                                       dow: 3'h1, hr: 6'h00, min: 7'h00, sec: 7'h00};

  function automatic logic [7:0] field_mask(input logic [2:0] ix);
    case (ix)
      IX_SEC, IX_MIN: field_mask = 8'h7F;
      IX_HR, IX_DATE: field_mask = 8'h3F;
      IX_DOW:         field_mask = 8'h07;
      IX_MON:         field_mask = 8'h1F;
      IX_YR:          field_mask = 8'hFF;
      default:        field_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] lo,
                                          input logic [7:0] hi);
    if (v == hi)             bcd_step = lo;
    else if (v[3:0] == 4'h9) bcd_step = {v[7:4] + 4'h1, 4'h0};
    else                     bcd_step = v + 8'h01;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) is_leap = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    else       is_leap = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      month_end = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_end = 8'h30;
      default:                    month_end = 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] get_field(input rtc_time_t t, input logic [2:0] ix);
    case (ix)
      IX_SEC:  get_field = {1'b0, t.sec};
      IX_MIN:  get_field = {1'b0, t.min};
      IX_HR:   get_field = {2'b0, t.hr};
      IX_DOW:  get_field = {5'b0, t.dow};
      IX_DATE: get_field = {2'b0, t.date};
      IX_MON:  get_field = {3'b0, t.mon};
      IX_YR:   get_field = t.yr;
      default: get_field = 8'h00;
    endcase
  endfunction

  function automatic rtc_time_t put_field(input rtc_time_t t, input logic [2:0] ix,
                                          input logic [7:0] d);
    put_field = t;
    case (ix)
      IX_SEC:  put_field.sec  = d[6:0];
      IX_MIN:  put_field.min  = d[6:0];
      IX_HR:   put_field.hr   = d[5:0];
      IX_DOW:  put_field.dow  = d[2:0];
      IX_DATE: put_field.date = d[5:0];
      IX_MON:  put_field.mon  = d[4:0];
      IX_YR:   put_field.yr   = d;
      default: ;
    endcase
  endfunction
endpackage

// File: rtl/rtc_sram.sv
module rtc_sram #(
  parameter int DEPTH = 512,
  localparam int RAW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [RAW-1:0] adr,
  input  logic [7:0]     din,
  output logic [7:0]     dout
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[adr] <= din;
    if (rd_en) dout <= mem[adr];
  end
endmodule

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt
);
  logic [7:0] s_sec, s_min, s_hr, s_dow, s_date, s_mon, s_yr, last_day;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    last_day = month_end({3'b0, cur.mon}, cur.yr);
    s_sec  = bcd_step({1'b0, cur.sec}, 8'h00, 8'h59);
    s_min  = bcd_step({1'b0, cur.min}, 8'h00, 8'h59);
    s_hr   = bcd_step({2'b0, cur.hr}, 8'h00, 8'h23);
    s_dow  = bcd_step({5'b0, cur.dow}, 8'h01, 8'h07);
    s_date = bcd_step({2'b0, cur.date}, 8'h01, last_day);
    s_mon  = bcd_step({3'b0, cur.mon}, 8'h01, 8'h12);
    s_yr   = bcd_step(cur.yr, 8'h00, 8'h99);
    c_min  = (cur.sec == 7'h59);
    c_hr   = c_min && (cur.min == 7'h59);
    c_day  = c_hr && (cur.hr == 6'h23);
    c_mon  = c_day && ({2'b0, cur.date} == last_day);
    c_yr   = c_mon && (cur.mon == 5'h12);
    nxt      = cur;
    nxt.sec  = s_sec[6:0];
    if (c_min) nxt.min  = s_min[6:0];
    if (c_hr)  nxt.hr   = s_hr[5:0];
    if (c_day) nxt.dow  = s_dow[2:0];
    if (c_day) nxt.date = s_date[5:0];
    if (c_mon) nxt.mon  = s_mon[4:0];
    if (c_yr)  nxt.yr   = s_yr;
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       stage_open,
  input  logic       stage_wr,
  input  logic [2:0] stage_ix,
  input  logic [7:0] stage_data,
  input  logic       commit,
  input  logic       snap_take,
  output rtc_time_t  live_o,
  output rtc_time_t  stage_o,
  output rtc_time_t  snap_o
);
  rtc_time_t stepped;

  rtc_calendar_step u_step (.cur(live_o), .nxt(stepped));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_o  <= TIME_RESET;
      stage_o <= TIME_RESET;
      snap_o  <= TIME_RESET;
    end else begin
      if (commit)       live_o <= stage_o;
      else if (tick_en) live_o <= stepped;
      if (stage_open)    stage_o <= live_o;
      else if (stage_wr) stage_o <= put_field(stage_o, stage_ix, stage_data);
      if (snap_take) snap_o <= live_o;
    end
  end

  assert_commit_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> live_o == $past(stage_o));
  assert_commit_beats_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tick_en) |=> live_o.sec == $past(stage_o.sec));
  assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !commit) |=> $stable(live_o));
  assert_sec_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !commit && live_o.sec == 7'h59) |=> live_o.sec == 7'h00);
  assert_snap_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> $stable(snap_o));
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int AW = 13,
  parameter int RAM_DEPTH = 512,
  localparam int RAW = $clog2(RAM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pwr_fail,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rst_out_n
);
  logic [7:0] spare [NREG];
  logic [2:0] ix;
  logic       in_bank, acc_ok, wr, rd, ctrl_wr;
  logic       w_bit, r_bit, osc_stop;
  logic       stage_open, commit, snap_take, stage_wr, tick_en;
  rtc_time_t  live, staged, snap, view;
  logic [7:0] reg_byte, reg_q, ram_q, rd_word;
  logic       sel_reg_q;

  assign ix         = addr[2:0];
  assign in_bank    = &addr[AW-1:3];
  assign acc_ok     = !ce_n && !pwr_fail;
  assign wr         = acc_ok && !we_n;
  assign rd         = acc_ok && we_n;
  assign ctrl_wr    = wr && in_bank && (ix == IX_CTRL);
  assign w_bit      = spare[IX_CTRL][7];
  assign r_bit      = spare[IX_CTRL][6];
  assign osc_stop   = spare[IX_SEC][7];
  assign stage_open = ctrl_wr && wdata[7] && !w_bit;
  assign commit     = ctrl_wr && !wdata[7] && w_bit;
  assign snap_take  = ctrl_wr && wdata[6] && !r_bit;
  assign stage_wr   = wr && in_bank && (ix != IX_CTRL) && w_bit;
  assign tick_en    = tick && !osc_stop;
  assign rst_out_n  = !pwr_fail;

  for (genvar g = 0; g < NREG; g++) begin : g_spare
    localparam logic [7:0] KEEP = ~field_mask(3'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) spare[g] <= 8'h00;
      else if (wr && in_bank && (ix == 3'(g))) spare[g] <= wdata & KEEP;
    end
  end

  rtc_time_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .stage_open(stage_open), .stage_wr(stage_wr), .stage_ix(ix), .stage_data(wdata),
    .commit(commit), .snap_take(snap_take),
    .live_o(live), .stage_o(staged), .snap_o(snap)
  );

  rtc_sram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .wr_en(wr && !in_bank), .rd_en(rd && !in_bank),
    .adr(addr[RAW-1:0]), .din(wdata), .dout(ram_q)
  );

  always_comb begin
    if (w_bit)      view = staged;
    else if (r_bit) view = snap;
    else            view = live;
    reg_byte = spare[ix] | (get_field(view, ix) & field_mask(ix));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q     <= 8'h00;
      sel_reg_q <= 1'b1;
    end else if (rd) begin
      reg_q     <= reg_byte;
      sel_reg_q <= in_bank;
    end
  end

  assign rd_word = sel_reg_q ? reg_q : ram_q;
  assign rdata   = oe_n ? 8'h00 : rd_word;

  assert_pwrfail_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> $stable(rd_word));
  assert_pwrfail_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> $stable(spare[IX_CTRL]));
endmodule

// File: tb/rtc_regbank_test.sv
`timescale 1ns/1ps
module rtc_regbank_test;
  localparam logic [12:0] A_CTRL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
    A_HR = 13'h1FFB, A_DOW = 13'h1FFC, A_DATE = 13'h1FFD, A_MON = 13'h1FFE, A_YR = 13'h1FFF;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pwr_fail = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rst_out_n;
  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  rtc_regbank uut (.clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_out_n(rst_out_n));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Monitor: every read accepted at an edge yields one scoreboard entry.
  initial forever begin
    @(posedge clk);
    if (rst_n && !ce_n && we_n && !pwr_fail) begin
      #5;
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R2: unexpected read, got %02h expected none", rdata);
      end else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [12:0] a, input logic [7:0] d, input logic with_tick);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; tick = with_tick;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; tick = 1'b0;
  endtask

  task automatic bus_rd(input logic [12:0] a, input logic [7:0] exp, input string tag,
                        input logic oe = 1'b0);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = oe;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 rdata after reset", rdata, 8'h00);
    chk("R8 rst_out_n idle", {7'b0, rst_out_n}, 8'h01);
    bus_rd(A_SEC,  8'h00, "R9 seconds reset");
    bus_rd(A_DOW,  8'h01, "R9 day reset");
    bus_rd(A_DATE, 8'h01, "R9 date reset");
    bus_rd(A_MON,  8'h01, "R9 month reset");
    bus_rd(A_YR,   8'h00, "R9 year reset");

    bus_wr(13'h0005, 8'hA5, 1'b0);
    bus_wr(13'h0100, 8'h3C, 1'b0);
    bus_rd(13'h0005, 8'hA5, "R2 ram low");
    bus_rd(13'h0100, 8'h3C, "R2 ram high");
    bus_rd(13'h0100, 8'h00, "R2 oe_n high blanks", 1'b1);

    // freeze clear: field bits ignored, spare bit 7 kept
    bus_wr(A_MIN, 8'hFF, 1'b0);
    bus_rd(A_MIN, 8'h80, "R3 R4 minutes spare kept, field ignored");

    bus_wr(A_CTRL, 8'h80, 1'b0);
    bus_wr(A_SEC, 8'h58, 1'b0);  bus_wr(A_MIN, 8'hD9, 1'b0);
    bus_wr(A_HR, 8'h23, 1'b0);   bus_wr(A_DOW, 8'h07, 1'b0);
    bus_wr(A_DATE, 8'h28, 1'b0); bus_wr(A_MON, 8'h02, 1'b0);
    bus_wr(A_YR, 8'h23, 1'b0);
    bus_rd(A_SEC, 8'h58, "R4 staged read");
    bus_rd(A_CTRL, 8'h80, "R3 freeze bit readback");
    bus_wr(A_CTRL, 8'h00, 1'b0);
    bus_rd(A_SEC, 8'h58, "R4 commit loads seconds");
    bus_rd(A_DOW, 8'h07, "R1 day field");

    pulse_tick();
    bus_rd(A_SEC, 8'h59, "R7 seconds step");
    pulse_tick();
    bus_rd(A_SEC,  8'h00, "R7 seconds wrap");
    bus_rd(A_MIN,  8'h80, "R7 minutes wrap");
    bus_rd(A_HR,   8'h00, "R7 hour wrap");
    bus_rd(A_DOW,  8'h01, "R7 day 7 to 1");
    bus_rd(A_DATE, 8'h01, "R7 Feb 28 end");
    bus_rd(A_MON,  8'h03, "R7 month carry");

    bus_wr(A_CTRL, 8'h80, 1'b0);
    bus_wr(A_SEC, 8'h59, 1'b0);  bus_wr(A_MIN, 8'hD9, 1'b0);
    bus_wr(A_HR, 8'h23, 1'b0);   bus_wr(A_DATE, 8'h28, 1'b0);
    bus_wr(A_MON, 8'h02, 1'b0);  bus_wr(A_YR, 8'h24, 1'b0);
    bus_wr(A_CTRL, 8'h00, 1'b0);
    pulse_tick();
    bus_rd(A_DATE, 8'h29, "R7 leap Feb 29");
    bus_rd(A_MON,  8'h02, "R7 leap month held");
    bus_rd(A_DOW,  8'h02, "R7 day step");

    bus_wr(A_CTRL, 8'h80, 1'b0);
    bus_wr(A_SEC, 8'h59, 1'b0);  bus_wr(A_MIN, 8'hD9, 1'b0);
    bus_wr(A_HR, 8'h23, 1'b0);   bus_wr(A_DATE, 8'h31, 1'b0);
    bus_wr(A_MON, 8'h12, 1'b0);  bus_wr(A_YR, 8'h99, 1'b0);
    bus_wr(A_CTRL, 8'h00, 1'b0);
    pulse_tick();
    bus_rd(A_YR,   8'h00, "R7 year wrap");
    bus_rd(A_MON,  8'h01, "R7 month wrap");
    bus_rd(A_DATE, 8'h01, "R7 Dec 31 end");

    bus_wr(A_SEC, 8'h80, 1'b0);
    pulse_tick();
    bus_rd(A_SEC, 8'h80, "R6 stopped tick ignored");
    bus_wr(A_SEC, 8'h00, 1'b0);
    pulse_tick();
    bus_rd(A_SEC, 8'h01, "R6 restarted");

    bus_wr(A_CTRL, 8'h40, 1'b0);
    pulse_tick(); pulse_tick(); pulse_tick();
    bus_rd(A_SEC, 8'h01, "R5 snapshot frozen");
    bus_rd(A_CTRL, 8'h40, "R3 snapshot bit readback");
    bus_wr(A_CTRL, 8'h00, 1'b0);
    bus_rd(A_SEC, 8'h04, "R5 counters kept running");

    bus_wr(A_CTRL, 8'h80, 1'b0);
    bus_wr(A_SEC, 8'h10, 1'b0);
    bus_wr(A_CTRL, 8'h00, 1'b1);
    bus_rd(A_SEC, 8'h10, "R10 load wins over tick");
    pulse_tick();
    bus_rd(A_SEC, 8'h11, "R10 next tick counts");

    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    chk("R8 rst_out_n low", {7'b0, rst_out_n}, 8'h00);
    bus_wr(13'h0005, 8'h11, 1'b0);
    bus_wr(A_CTRL, 8'h80, 1'b0);
    @(negedge clk); addr = 13'h0005; ce_n = 1'b0; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    chk("R8 rdata held", rdata, 8'h11);
    pwr_fail = 1'b0;
    @(negedge clk);
    chk("R8 rst_out_n released", {7'b0, rst_out_n}, 8'h01);
    bus_rd(13'h0005, 8'hA5, "R8 ram write blocked");
    bus_rd(A_CTRL, 8'h00, "R8 control write blocked");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R2: got %0d pending reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule